// File: doc/BRIEF.md
# Preloadable Interval Tick Timer

This block is a 16-bit interval timer that counts upward on a slow tick enable (nominally 160 kHz), supplied as a one-cycle strobe in the system clock domain. When the count stands at 0xFFFF and another tick arrives, the counter reloads from a software preload value instead of rolling over to zero. That reload also increments a small saturating overflow tally and latches an interrupt pending flag.

The period in ticks is therefore 0x10000 minus the preload. Software picks the preload as 0x10000 − 160000/f to obtain an event rate of f.

Software reaches four registers through a simple halfword write port and a combinational read port: the preload, the live count, a control byte and an interrupt-control byte. The control byte takes one of four command codes: clear, arm, stop-with-hold and run. The overflow tally reads back in the upper nibble of the control byte. The interrupt-control byte carries the request level, an enable bit, and a pending bit that is cleared by writing a one. The block drives an interrupt request and the level it is requested at.

Top module: `tick_timer`

## Requirements
- R1: Register address 0 holds the 16-bit preload and address 1 the 16-bit live count; each is written from `wr_data` when `wr_en` is high with that address and reads back on `rd_data` independently of the other.
- R2: Address 2 is the control byte. A write stores `wr_data[2:0]` as the command and ignores bits 7:3. A read returns the command in bits 2:0, zero in bit 3 and the overflow tally in bits 7:4.
- R3: While command bit 0 is 0 (clear, code 0x0), the count is forced to the preload and the tally to 0 on every clock. Ticks and count writes have no effect in this state.
- R4: With command bits 0 and 2 both set (run, code 0x7), each tick increments the count by one.
- R5: With command code 0x1 (arm) or 0x3 (stop), the count and the tally hold their values while ticks arrive.
- R6: A counting tick while the count is 0xFFFF loads the preload, increments the 4-bit tally (saturating at 15) and sets the pending flag.
- R7: Address 3 is the interrupt-control byte: bits 2:0 are the level, bit 3 the enable, and bit 7 reads as the pending flag. Writing 1 to bit 7 clears the pending flag, unless a wrap occurs in the same cycle, in which case the flag stays set.
- R8: `irq` is high exactly when pending, enable and a non-zero level all hold. `irq_level` then equals the level, and it is 0 whenever `irq` is low.
- R9: A count write while running takes effect on the next clock and overrides a tick in the same cycle.
- R10: After reset, all four registers read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count enable at the tick rate |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select (0 preload, 1 count, 2 control, 3 interrupt control) |
| wr_data | input | 16 | Write data; byte registers use bits 7:0 |
| rd_data | output | 16 | Combinational read data for `addr` |
| irq | output | 1 | Interrupt request |
| irq_level | output | 3 | Level of the active request, 0 when idle |

## Verification
The main function is swept over the four shortest periods (preloads 0xFFFC to 0xFFFF), with tick bursts of 0 to 19 ticks each. Comparing the count, tally and pending flag against the arithmetic quotient and remainder separates off-by-one reload errors from wrong wrap detection and from a tally that fails to saturate. A second sweep covers all 16 enable/level combinations with a pending flag set, and shows whether level zero and the enable each mask the request. Single-cycle collisions (a tick together with a count write, and a wrap together with an acknowledge) settle which action takes priority.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int LVL_W       = 3;
  localparam int CMD_W       = 3;
  localparam int CMD_LIVE    = 0;
  localparam int CMD_RUN     = 2;
  localparam int IC_EN_BIT   = 3;
  localparam int IC_PEND_BIT = 7;
  localparam int TALLY_LSB   = 4;

  typedef enum logic [1:0] {
    SEL_PRELOAD = 2'd0,
    SEL_COUNT   = 2'd1,
    SEL_CTRL    = 2'd2,
    SEL_INTCTL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tt_regs.sv
module tt_regs
  import tt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] preload,
  output logic [CMD_W-1:0] cmd,
  output logic             int_en,
  output logic [LVL_W-1:0] int_lvl,
  output logic             cnt_wr,
  output logic             ack
);
  logic             pre_ld, cmd_ld, ic_ld;
  logic [CNT_W-1:0] preload_d;
  logic [CMD_W-1:0] cmd_d;
  logic             en_d;
  logic [LVL_W-1:0] lvl_d;

  always_comb begin
    pre_ld    = wr_en && (addr == SEL_PRELOAD);
    cnt_wr    = wr_en && (addr == SEL_COUNT);
    cmd_ld    = wr_en && (addr == SEL_CTRL);
    ic_ld     = wr_en && (addr == SEL_INTCTL);
    ack       = ic_ld && wr_data[IC_PEND_BIT];
    preload_d = pre_ld ? wr_data : preload;
    cmd_d     = cmd_ld ? wr_data[CMD_W-1:0] : cmd;
    en_d      = ic_ld ? wr_data[IC_EN_BIT] : int_en;
    lvl_d     = ic_ld ? wr_data[LVL_W-1:0] : int_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preload <= '0;
      cmd     <= '0;
      int_en  <= 1'b0;
      int_lvl <= '0;
    end else begin
      preload <= preload_d;
      cmd     <= cmd_d;
      int_en  <= en_d;
      int_lvl <= lvl_d;
    end
  end

  assert_cmd_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SEL_CTRL) |=> cmd == $past(wr_data[CMD_W-1:0]));
endmodule

// File: rtl/tt_counter.sv
module tt_counter
  import tt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TALLY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [CMD_W-1:0]   cmd,
  input  logic [CNT_W-1:0]   preload,
  input  logic               cnt_wr,
  input  logic [CNT_W-1:0]   wr_data,
  output logic [CNT_W-1:0]   count,
  output logic [TALLY_W-1:0] tally,
  output logic               wrap
);
  localparam logic [CNT_W-1:0]   CNT_TOP   = '1;
  localparam logic [TALLY_W-1:0] TALLY_MAX = '1;

  logic               live, run, step;
  logic [CNT_W-1:0]   count_d;
  logic [TALLY_W-1:0] tally_d;

  always_comb begin
    live    = cmd[CMD_LIVE];
    run     = live && cmd[CMD_RUN];
    step    = run && tick && !cnt_wr;
    wrap    = step && (count == CNT_TOP);
    count_d = count;
    tally_d = tally;
    if (!live) begin
      count_d = preload;
      tally_d = '0;
    end else if (cnt_wr) begin
      count_d = wr_data;
    end else if (step) begin
      if (wrap) begin
        count_d = preload;
        if (tally != TALLY_MAX) tally_d = tally + 1'b1;
      end else begin
        count_d = count + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      tally <= '0;
    end else begin
      count <= count_d;
      tally <= tally_d;
    end
  end

  assert_clear_forces_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd[CMD_LIVE] |=> (count == $past(preload)) && (tally == '0));
  assert_hold_when_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd[CMD_LIVE] && !cmd[CMD_RUN] && !cnt_wr) |=> $stable(count) && $stable(tally));
  assert_tally_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tally == TALLY_MAX && cmd[CMD_LIVE]) |=> tally == TALLY_MAX);
  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && cmd[CMD_LIVE]) |=> count == $past(wr_data));
endmodule

// File: rtl/tt_irq.sv
module tt_irq
  import tt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic             ack,
  input  logic             int_en,
  input  logic [LVL_W-1:0] int_lvl,
  output logic             pend,
  output logic             irq,
  output logic [LVL_W-1:0] irq_level
);
  logic pend_d;

  always_comb begin
    pend_d    = wrap ? 1'b1 : (ack ? 1'b0 : pend);
    irq       = pend && int_en && (int_lvl != '0);
    irq_level = irq ? int_lvl : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end

  assert_wrap_sets_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> pend);
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wrap) |=> !pend);
  assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> irq_level == '0);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int TALLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq,
  output logic [LVL_W-1:0] irq_level
);
  logic [CNT_W-1:0]   preload, count;
  logic [CMD_W-1:0]   cmd;
  logic               int_en, cnt_wr, ack, wrap, pend;
  logic [LVL_W-1:0]   int_lvl;
  logic [TALLY_W-1:0] tally;

  tt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .preload(preload), .cmd(cmd), .int_en(int_en), .int_lvl(int_lvl),
    .cnt_wr(cnt_wr), .ack(ack)
  );

  tt_counter #(.CNT_W(CNT_W), .TALLY_W(TALLY_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd(cmd), .preload(preload),
    .cnt_wr(cnt_wr), .wr_data(wr_data), .count(count), .tally(tally), .wrap(wrap)
  );

  tt_irq u_irq (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .ack(ack), .int_en(int_en),
    .int_lvl(int_lvl), .pend(pend), .irq(irq), .irq_level(irq_level)
  );

  always_comb begin
    rd_data = '0;
    case (addr)
      SEL_PRELOAD: rd_data = preload;
      SEL_COUNT:   rd_data = count;
      SEL_CTRL: begin
        rd_data[CMD_W-1:0]            = cmd;
        rd_data[TALLY_LSB +: TALLY_W] = tally;
      end
      default: begin
        rd_data[LVL_W-1:0]  = int_lvl;
        rd_data[IC_EN_BIT]  = int_en;
        rd_data[IC_PEND_BIT] = pend;
      end
    endcase
  end

  assert_irq_needs_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_level != '0) && (rd_data[IC_PEND_BIT] || addr != SEL_INTCTL));
  assert_run_increments_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && cmd == 3'b111 && count != '1) |=> count == $past(count) + 1'b1);
endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq;
  logic [2:0]  irq_level;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tick_timer u_tick_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .irq_level(irq_level)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic t = 1'b0);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1; tick = t;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R10 reset register", v, 0);
    end
    check("R10 reset irq", irq, 0);

    // R1: separate preload and count access
    wr(2'd2, 16'h0007);
    wr(2'd0, 16'hABCD);
    wr(2'd1, 16'h1234);
    rd(2'd0, v); check("R1 preload readback", v, 16'hABCD);
    rd(2'd1, v); check("R1 count readback", v, 16'h1234);

    // R2: control readback, upper bits of write ignored
    wr(2'd2, 16'h00F3);
    rd(2'd2, v); check("R2 control readback", v, 16'h0003);

    // R5: stop and arm codes hold
    wr(2'd1, 16'h0100);
    ticks(5);
    rd(2'd1, v); check("R5 stop holds count", v, 16'h0100);
    wr(2'd2, 16'h0001);
    ticks(4);
    rd(2'd1, v); check("R5 arm holds count", v, 16'h0100);

    // R4: run increments
    wr(2'd2, 16'h0007);
    ticks(6);
    rd(2'd1, v); check("R4 run count", v, 16'h0106);

    // R9: count write overrides tick
    wr(2'd1, 16'h5000, 1'b1);
    rd(2'd1, v); check("R9 write beats tick", v, 16'h5000);

    // R3: clear forces preload, ignores ticks and writes
    wr(2'd2, 16'h0000);
    @(negedge clk);
    rd(2'd1, v); check("R3 clear loads preload", v, 16'hABCD);
    wr(2'd1, 16'h2222);
    ticks(3);
    rd(2'd1, v); check("R3 clear ignores write/tick", v, 16'hABCD);

    // R6/R3: wrap sweep over short periods
    for (int p = 1; p <= 4; p++) begin
      for (int n = 0; n < 20; n++) begin
        int wraps;
        int exp_tally;
        logic [15:0] pre;
        pre = 16'(32'h10000 - p);
        wraps = n / p;
        exp_tally = (wraps > 15) ? 15 : wraps;
        wr(2'd2, 16'h0000);
        wr(2'd0, pre);
        wr(2'd3, 16'h0080);
        wr(2'd2, 16'h0007);
        rd(2'd2, v); check("R3 tally cleared", v, 16'h0007);
        if (n > 0) ticks(n);
        rd(2'd1, v); check("R6 count after sweep", v, 32'(pre) + (n % p));
        rd(2'd2, v); check("R6 tally after sweep", v, (exp_tally << 4) | 7);
        rd(2'd3, v); check("R6 pending after sweep", v[7], (wraps > 0) ? 1 : 0);
      end
    end

    // R8: gating sweep with pending set
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'hFFFF);
    wr(2'd2, 16'h0007);
    ticks(1);
    for (int en = 0; en < 2; en++) begin
      for (int lv = 0; lv < 8; lv++) begin
        int exp_irq;
        wr(2'd3, 16'((en << 3) | lv));
        exp_irq = (en == 1 && lv != 0) ? 1 : 0;
        check("R8 irq gating", irq, exp_irq);
        check("R8 irq level", irq_level, exp_irq ? lv : 0);
        rd(2'd3, v); check("R7 intctl readback", v, 16'h0080 | 16'((en << 3) | lv));
      end
    end

    // R7: acknowledge clears, wrap in same cycle wins
    wr(2'd3, 16'h008D);
    rd(2'd3, v); check("R7 ack clears pending", v, 16'h000D);
    check("R7 irq low after ack", irq, 0);
    wr(2'd3, 16'h008D, 1'b1);
    rd(2'd3, v); check("R7 wrap beats ack", v, 16'h008D);
    check("R8 irq level 5", irq_level, 5);

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule